// File: doc/BRIEF.md
# Interleaved Storage Bank Scheduler

This block sits in front of a main memory built from several independent storage units. Each unit moves one 16-byte quadword per access. Once a unit starts a storage cycle it stays occupied for a fixed number of clocks. The scheduler works out which unit a request address falls in and tracks each unit's remaining busy time. It admits at most one reference per clock, and only when the target unit is idle. A request aimed at an occupied unit stalls in place, and requests are never reordered.

Two static settings choose the organisation. One picks two or four units. The other picks a storage cycle of 12 or 13 clocks. When a read reaches the last clock of its unit's cycle, the block raises a completion strobe that carries the unit number. The storage arrays and their error correction lie outside the block.

Top module: `stor_interleave`

## Requirements
- R1: When `four_way` is 1, a request goes to unit `req_addr[5:4]` (unit 0 = 0, 1 = 1, 2 = 2, 3 = 3). Quadword addresses 0, 16, 32, 48 and 64 therefore map to units 0, 1, 2, 3 and 0. On acceptance, `unit_sel` bit k (with k the unit number) is 1.
- R2: When `four_way` is 0, the unit is `req_addr[4]`, and `unit_sel` bits 3 and 2 are never set.
- R3: `req_accept` is 1 exactly when `req_valid` is 1 and the target unit is not busy. `req_stall` is `req_valid` and not `req_accept`. A stalled requester holds its address and write flag unchanged until acceptance.
- R4: After a unit is accepted in clock t, it accepts no request in clocks t+1 to t+N-1. N is 13 when `long_cycle` is 1 and 12 otherwise, sampled at acceptance.
- R5: A unit accepted in clock t accepts a waiting request to itself in clock t+N.
- R6: At most one `unit_sel` bit is 1 in any clock, and `unit_sel` is zero when nothing is accepted.
- R7: For a read (`req_write` 0) accepted in clock t, `done_valid` is 1 in clock t+N-1 with `done_unit` equal to the unit number. Writes raise no completion strobe.
- R8: After reset, all units are idle. `req_accept`, `req_stall`, `unit_sel` and `done_valid` stay 0 while `req_valid` is 0.
- R9: While one unit is busy, a request to a different idle unit is accepted in the same clock it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| four_way | input | 1 | 1 = four units, 0 = two units |
| long_cycle | input | 1 | 1 = 13-clock storage cycle, 0 = 12 |
| req_valid | input | 1 | A reference is presented |
| req_addr | input | 24 | Byte address of the reference |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_accept | output | 1 | Reference taken this clock |
| req_stall | output | 1 | Reference held, target unit busy |
| unit_sel | output | 4 | One-hot unit started this clock |
| done_valid | output | 1 | Read finishing its storage cycle |
| done_unit | output | 2 | Unit whose read finishes |

## Verification
A sequential address sweep in four-way mode spreads requests across all units. It separates correct overlap (R9) from a design that serialises all traffic, and it stalls only when the sweep wraps back to a still-busy unit. Repeated hits to one address measure the exact re-acceptance gap for both cycle lengths, which exposes an off-by-one in R4/R5. A two-way sweep with address bit 5 toggling shows that only bit 4 selects the unit. Random addresses with mixed reads and writes check that completions follow reads alone and report the right unit.

// File: rtl/stor_interleave.sv
module stor_interleave #(
  parameter int ADDR_W    = 24,
  parameter int UNITS     = 4,
  parameter int QW_LSB    = 4,
  parameter int SHORT_CYC = 12,
  parameter int LONG_CYC  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              four_way,
  input  logic              long_cycle,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              req_accept,
  output logic              req_stall,
  output logic [UNITS-1:0]  unit_sel,
  output logic              done_valid,
  output logic [1:0]        done_unit
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam int GW = 6;

  logic [1:0]      tgt;
  logic [CW-1:0]   len;
  logic [UNITS-1:0] busy, fin;

  assign tgt        = four_way ? req_addr[QW_LSB+1:QW_LSB] : {1'b0, req_addr[QW_LSB]};
  assign len        = long_cycle ? CW'(LONG_CYC) : CW'(SHORT_CYC);
  assign req_accept = req_valid && !busy[tgt];
  assign req_stall  = req_valid && !req_accept;
  assign unit_sel   = req_accept ? UNITS'(1) << tgt : '0;
  assign done_valid = |fin;

  always_comb begin
    done_unit = '0;
    for (int k = 0; k < UNITS; k++)
      if (fin[k]) done_unit = 2'(k);
  end

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    logic [CW-1:0] cnt;
    logic          rd;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        rd  <= 1'b0;
      end else if (unit_sel[g]) begin
        cnt <= len - CW'(1);
        rd  <= !req_write;
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
    assign busy[g] = cnt != '0;
    assign fin[g]  = rd && cnt == CW'(1);

    // independent watch of each unit: clocks since its last start
    logic [GW-1:0] gap;
    logic [CW-1:0] glen;
    logic          seen, lrd;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gap <= '0; glen <= '0; seen <= 1'b0; lrd <= 1'b0;
      end else if (unit_sel[g]) begin
        gap <= GW'(1); glen <= len; seen <= 1'b1; lrd <= !req_write;
      end else if (gap != '1) begin
        gap <= gap + GW'(1);
      end
    end

    assert_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      unit_sel[g] |-> (!seen || gap >= GW'(glen)));
    assert_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && gap >= GW'(glen) && req_valid && tgt == 2'(g)) |-> req_accept);
    assert_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_unit == 2'(g)) |-> (seen && lrd && gap == GW'(glen) - GW'(1)));
  end

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_sel) && (req_accept || unit_sel == '0));
  assert_twoway_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !four_way |-> unit_sel[UNITS-1:2] == '0);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |=> (req_valid && $stable(req_addr) && $stable(req_write)));
endmodule

// File: tb/test_stor_interleave.sv
module test_stor_interleave;
  logic        clk = 0, rst_n = 0, four_way = 1, long_cycle = 0;
  logic        req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic        req_accept, req_stall, done_valid;
  logic [3:0]  unit_sel;
  logic [1:0]  done_unit;

  stor_interleave i_stor_interleave (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int free_at[4], done_at[4];
  bit dpend[4];
  bit finished = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d actual %0d expected %0d", rq, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [23:0] a, input bit w, output bit acc);
    int u, n, eu;
    bit e_acc, e_done, other_busy;
    logic [3:0] e_sel;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = w;
    #1;
    u = four_way ? int'(a[5:4]) : int'(a[4]);
    n = long_cycle ? 13 : 12;
    e_acc = v && cyc >= free_at[u];
    e_sel = e_acc ? 4'(1 << u) : 4'b0;
    other_busy = 0;
    for (int k = 0; k < 4; k++) if (k != u && cyc < free_at[k]) other_busy = 1;
    e_done = 0; eu = 0;
    for (int k = 0; k < 4; k++) if (dpend[k] && done_at[k] == cyc) begin e_done = 1; eu = k; end
    if (!v) chk(req_accept == 0 && req_stall == 0 && unit_sel == 0, "R8", "idle outputs",
                {req_accept, req_stall}, 0);
    else if (cyc < free_at[u]) chk(req_accept == 0, "R4", "accept to busy unit", req_accept, 0);
    else if (other_busy) chk(req_accept == 1, "R9", "accept beside busy unit", req_accept, 1);
    else chk(req_accept == e_acc, "R5", "accept to free unit", req_accept, e_acc);
    chk(req_stall == (v && !e_acc), "R3", "stall", req_stall, v && !e_acc);
    chk(unit_sel == e_sel, four_way ? "R1" : "R2", "unit_sel", unit_sel, e_sel);
    chk($countones(unit_sel) <= 1, "R6", "unit_sel one-hot", unit_sel, e_sel);
    chk(done_valid == e_done, "R7", "done_valid", done_valid, e_done);
    if (e_done) chk(done_unit == 2'(eu), "R7", "done_unit", done_unit, eu);
    for (int k = 0; k < 4; k++) if (dpend[k] && done_at[k] == cyc) dpend[k] = 0;
    if (e_acc) begin
      free_at[u] = cyc + n;
      if (!w) begin dpend[u] = 1; done_at[u] = cyc + n - 1; end
    end
    acc = e_acc;
    cyc++;
  endtask

  task automatic req(input logic [23:0] a, input bit w);
    bit acc;
    do step(1, a, w, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, '0, 0, acc);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin free_at[k] = 0; done_at[k] = 0; dpend[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle(3);                                      // R8 reset state
    // four-way sequential sweep, 12 clocks, reads (R1, R9, R7)
    for (int i = 0; i < 12; i++) req(24'(i * 16), 0);
    idle(16);
    // repeated hits to one unit (R4, R5) short then long
    for (int i = 0; i < 4; i++) req(24'h000040, 0);
    idle(16);
    long_cycle = 1;
    for (int i = 0; i < 4; i++) req(24'h000470, 1);
    for (int i = 0; i < 8; i++) req(24'(i * 16 + 24'h100), i[0]);
    idle(16);
    // two-way mode, bit 5 toggling (R2)
    four_way = 0;
    for (int i = 0; i < 10; i++) req(24'(i * 16), 0);
    idle(16);
    long_cycle = 0;
    for (int i = 0; i < 40; i++) req(24'($urandom), 1'($urandom));
    idle(16);
    // random four-way traffic with idle gaps
    four_way = 1;
    for (int i = 0; i < 120; i++) begin
      req(24'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) idle(int'($urandom % 5));
    end
    idle(16);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired cycle %0d actual 0 expected 1", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule